// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Unit

This unit keeps, for each CPU of a small multiprocessor, one pending bit for an inter-processor interrupt (IPI) and one pending bit for an interval-timer interrupt. Each pending bit drives that CPU's interrupt output directly. Software changes the bits by writing a 64-bit control word. A single control write can request IPIs, clear IPIs and clear timer interrupts at the same time, because each action has its own nibble field. Three narrower registers also exist: one clears IPI bits, one clears timer bits, and one posts IPIs. A timer tick input posts a timer interrupt to every CPU.

Each pending bit is a two-state machine. The states are `LINE_IDLE` and `LINE_PEND`. The set transition (`LINE_IDLE` to `LINE_PEND`) is taken when any set source selects the bit. The clear transition (`LINE_PEND` to `LINE_IDLE`) is taken when a clear source selects the bit and no set source does. A set on a bit that is already pending changes nothing, and so does a clear on a bit that is idle. A write that selects nothing is rejected with a one-cycle error pulse and has no effect. A read of the control word returns the number of the requesting CPU and a copy of both pending vectors.

Register selects:
- 0 is the control word.
- 1 is the IPI-clear register.
- 2 is the timer-clear register.
- 3 is the IPI-post register.

Top module: `ipu_irq_unit`

## Requirements
- R1: After reset, every pending bit is clear, `ipi_irq_o`, `tmr_irq_o` and `err_o` are low, and `rdata_o` is zero.
- R2: A write to select 0 posts an IPI to CPU n when bit 12+n of the data is set.
- R3: A write to select 0 clears the pending IPI of CPU n when bit 8+n of the data is set.
- R4: A write to select 0 clears the pending timer interrupt of CPU n when bit 4+n of the data is set.
- R5: A write to select 0 that has only bit 28 set raises no error and changes no pending bit.
- R6: A write to select 0 with bits 15:4 and bit 28 all zero sets `err_o` high for the next cycle and changes no pending bit. All other data bits are ignored.
- R7: Posting an IPI that is already pending, or clearing an IPI or timer bit that is not pending, leaves the state unchanged and raises no error.
- R8: A cycle with `tick_i` high makes every CPU's timer bit pending in the next cycle.
- R9: Writes to selects 1, 2 and 3 use data bits NCPU-1:0 as the CPU vector. Select 1 clears IPIs, select 2 clears timer bits, and select 3 posts IPIs. An all-zero vector gives the error pulse of R6 and no change.
- R10: `rdata_o` updates in the cycle after `rd_en_i` and shows the state from before that edge. For select 0 it holds the requester number `cpu_id_i` in bits 1:0, the IPI vector at bit 8, the timer vector at bit 4, and zeros elsewhere. Selects 1 and 2 return the IPI or timer vector in the low bits. Select 3 returns zero.
- R11: When a set and a clear select the same bit in the same cycle, the bit ends up pending.
- R12: `ipi_irq_o` and `tmr_irq_o` equal the pending vectors and change in the cycle after the write or tick that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| sel_i | input | 2 | Register select |
| wdata_i | input | 64 | Write data |
| cpu_id_i | input | 2 | Number of the CPU making the access |
| tick_i | input | 1 | Timer tick, posts to all CPUs |
| rdata_o | output | 64 | Read data, registered |
| err_o | output | 1 | Rejected-write pulse |
| ipi_irq_o | output | NCPU | Per-CPU inter-processor interrupt |
| tmr_irq_o | output | NCPU | Per-CPU timer interrupt |

## Verification
The bench builds the unit with its default of four CPUs, so every bit of each nibble field maps to a real CPU. This allows every combination of simultaneous request, clear and tick on each bit to be reached. The random data is drawn nibble by nibble, and each nibble has a high chance of being zero. This makes empty fields and rejected writes common, and combined requests that touch overlapping CPUs are also frequent.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
    localparam int SEL_W       = 2;
    localparam int CPUID_W     = 2;
    localparam int NIB_W       = 4;
    localparam int F_IPI_REQ   = 12;
    localparam int F_IPI_CLR   = 8;
    localparam int F_TMR_CLR   = 4;
    localparam int F_NXM_ACK   = 28;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL    = 2'd0,
        SEL_IPI_CLR = 2'd1,
        SEL_TMR_CLR = 2'd2,
        SEL_IPI_SET = 2'd3
    } sel_e;

    typedef enum logic {
        LINE_IDLE = 1'b0,
        LINE_PEND = 1'b1
    } line_state_e;
endpackage

// File: rtl/ipu_wr_decode.sv
module ipu_wr_decode
    import ipu_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int DATA_W = 64
) (
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NCPU-1:0]   ipi_set_o,
    output logic [NCPU-1:0]   ipi_clr_o,
    output logic [NCPU-1:0]   tmr_clr_o,
    output logic              bad_wr_o
);
    sel_e            sel;
    logic            ctrl_any;
    logic [NCPU-1:0] vec;

    assign sel = sel_e'(sel_i);
    assign vec = wdata_i[NCPU-1:0];
    assign ctrl_any = (|wdata_i[F_IPI_REQ +: NIB_W]) | (|wdata_i[F_IPI_CLR +: NIB_W])
                    | (|wdata_i[F_TMR_CLR +: NIB_W]) | wdata_i[F_NXM_ACK];

    always_comb begin
        ipi_set_o = '0;
        ipi_clr_o = '0;
        tmr_clr_o = '0;
        bad_wr_o  = 1'b0;
        if (wr_en_i) begin
            unique case (sel)
                SEL_CTRL: begin
                    ipi_set_o = wdata_i[F_IPI_REQ +: NCPU];
                    ipi_clr_o = wdata_i[F_IPI_CLR +: NCPU];
                    tmr_clr_o = wdata_i[F_TMR_CLR +: NCPU];
                    bad_wr_o  = !ctrl_any;
                end
                SEL_IPI_CLR: begin
                    ipi_clr_o = vec;
                    bad_wr_o  = (vec == '0);
                end
                SEL_TMR_CLR: begin
                    tmr_clr_o = vec;
                    bad_wr_o  = (vec == '0);
                end
                SEL_IPI_SET: begin
                    ipi_set_o = vec;
                    bad_wr_o  = (vec == '0);
                end
                default: bad_wr_o = 1'b0;
            endcase
        end
    end

    // R6 / R9: a rejected write never produces an action
    always_comb begin
        if (bad_wr_o) begin
            assert_bad_inert_R6: assert ((ipi_set_o | ipi_clr_o | tmr_clr_o) == '0)
                else $error("rejected write still produced an action");
        end
    end
endmodule

// File: rtl/ipu_line.sv
module ipu_line
    import ipu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    line_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            LINE_IDLE: if (set_i)           state_nx = LINE_PEND;
            LINE_PEND: if (clr_i && !set_i) state_nx = LINE_IDLE;
            default:                        state_nx = LINE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LINE_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            LINE_PEND: pend_o = 1'b1;
            default:   pend_o = 1'b0;
        endcase
    end

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o)
        else $error("set did not leave line pending");

    assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o)
        else $error("clear without set left line pending");
endmodule

// File: rtl/ipu_rd_mux.sv
module ipu_rd_mux
    import ipu_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int DATA_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [CPUID_W-1:0] cpu_id_i,
    input  logic [NCPU-1:0]    ipi_pend_i,
    input  logic [NCPU-1:0]    tmr_pend_i,
    output logic [DATA_W-1:0]  rdata_o
);
    logic [DATA_W-1:0] rd_nx;

    always_comb begin
        rd_nx = '0;
        unique case (sel_e'(sel_i))
            SEL_CTRL: begin
                rd_nx[CPUID_W-1:0]        = cpu_id_i;
                rd_nx[F_IPI_CLR +: NCPU]  = ipi_pend_i;
                rd_nx[F_TMR_CLR +: NCPU]  = tmr_pend_i;
            end
            SEL_IPI_CLR: rd_nx[NCPU-1:0] = ipi_pend_i;
            SEL_TMR_CLR: rd_nx[NCPU-1:0] = tmr_pend_i;
            SEL_IPI_SET: rd_nx = '0;
            default:     rd_nx = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= rd_nx;
    end

    assert_ctrl_cpu_id_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && sel_i == SEL_CTRL) |=> rdata_o[CPUID_W-1:0] == $past(cpu_id_i))
        else $error("control read lost requester number");
endmodule

// File: rtl/ipu_irq_unit.sv
module ipu_irq_unit
    import ipu_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int DATA_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [1:0]         sel_i,
    input  logic [63:0]        wdata_i,
    input  logic [1:0]         cpu_id_i,
    input  logic               tick_i,
    output logic [63:0]        rdata_o,
    output logic               err_o,
    output logic [NCPU-1:0]    ipi_irq_o,
    output logic [NCPU-1:0]    tmr_irq_o
);
    localparam int KINDS = 2;

    logic [NCPU-1:0] ipi_set, ipi_clr, tmr_clr, tmr_set;
    logic            bad_wr;
    logic [NCPU-1:0] set_v [KINDS];
    logic [NCPU-1:0] clr_v [KINDS];
    logic [NCPU-1:0] pend_v [KINDS];

    ipu_wr_decode #(.NCPU(NCPU), .DATA_W(DATA_W)) u_dec (
        .wr_en_i  (wr_en_i),
        .sel_i    (sel_i),
        .wdata_i  (wdata_i),
        .ipi_set_o(ipi_set),
        .ipi_clr_o(ipi_clr),
        .tmr_clr_o(tmr_clr),
        .bad_wr_o (bad_wr)
    );

    assign tmr_set  = {NCPU{tick_i}};
    assign set_v[0] = ipi_set;
    assign clr_v[0] = ipi_clr;
    assign set_v[1] = tmr_set;
    assign clr_v[1] = tmr_clr;

    for (genvar k = 0; k < KINDS; k++) begin : g_kind
        for (genvar c = 0; c < NCPU; c++) begin : g_cpu
            ipu_line u_line (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_v[k][c]),
                .clr_i (clr_v[k][c]),
                .pend_o(pend_v[k][c])
            );
        end
    end

    assign ipi_irq_o = pend_v[0];
    assign tmr_irq_o = pend_v[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= bad_wr;
    end

    ipu_rd_mux #(.NCPU(NCPU), .DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .sel_i     (sel_i),
        .cpu_id_i  (cpu_id_i),
        .ipi_pend_i(pend_v[0]),
        .tmr_pend_i(pend_v[1]),
        .rdata_o   (rdata_o)
    );

    assert_tick_posts_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (&tmr_irq_o))
        else $error("tick did not post to every CPU");

    assert_ipi_rise_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ipi_irq_o & ~$past(ipi_irq_o))) |-> $past(wr_en_i))
        else $error("IPI rose without a write");

    assert_err_keeps_ipi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (ipi_irq_o == $past(ipi_irq_o)))
        else $error("rejected write changed IPI state");

    assert_err_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(wr_en_i))
        else $error("error pulse without a write");
endmodule

// File: tb/ipu_irq_unit_test.sv
module ipu_irq_unit_test;
    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
    logic [1:0]  sel = '0, cpu_id = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        err;
    logic [NCPU-1:0] ipi_irq, tmr_irq;

    int checks = 0;
    int errors = 0;
    logic [NCPU-1:0] m_ipi = '0, m_tmr = '0;

    always #2 clk = ~clk;

    ipu_irq_unit #(.NCPU(NCPU), .DATA_W(64)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .sel_i(sel), .wdata_i(wdata), .cpu_id_i(cpu_id), .tick_i(tick),
        .rdata_o(rdata), .err_o(err), .ipi_irq_o(ipi_irq), .tmr_irq_o(tmr_irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_err(input logic we, input logic [1:0] s, input logic [63:0] d);
        if (!we) return 1'b0;
        if (s == 2'd0) return !((|d[15:4]) || d[28]);
        return (d[NCPU-1:0] == '0);
    endfunction

    function automatic logic [63:0] exp_rd(input logic [1:0] s, input logic [1:0] cid,
                                           input logic [NCPU-1:0] ip, input logic [NCPU-1:0] tm);
        logic [63:0] r = '0;
        case (s)
            2'd0: begin r[1:0] = cid; r[8 +: NCPU] = ip; r[4 +: NCPU] = tm; end
            2'd1: r[NCPU-1:0] = ip;
            2'd2: r[NCPU-1:0] = tm;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic op(input logic we, input logic re, input logic [1:0] s,
                      input logic [63:0] d, input logic [1:0] cid, input logic tk,
                      input string tag);
        logic [NCPU-1:0] is, ic, tc, ts;
        logic [63:0] erd;
        logic ee;
        wr_en = we; rd_en = re; sel = s; wdata = d; cpu_id = cid; tick = tk;
        is = '0; ic = '0; tc = '0;
        if (we && s == 2'd0) begin is = d[12 +: NCPU]; ic = d[8 +: NCPU]; tc = d[4 +: NCPU]; end
        if (we && s == 2'd1) ic = d[NCPU-1:0];
        if (we && s == 2'd2) tc = d[NCPU-1:0];
        if (we && s == 2'd3) is = d[NCPU-1:0];
        ts  = tk ? '1 : '0;
        erd = exp_rd(s, cid, m_ipi, m_tmr);
        ee  = exp_err(we, s, d);
        m_ipi = is | (m_ipi & ~ic);
        m_tmr = ts | (m_tmr & ~tc);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
        check({tag, " ipi"}, 64'(ipi_irq), 64'(m_ipi));
        check({tag, " tmr"}, 64'(tmr_irq), 64'(m_tmr));
        check({tag, " err"}, 64'(err), 64'(ee));
        if (re) check({tag, " rdata"}, rdata, erd);
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ipi", 64'(ipi_irq), 64'h0);
        check("R1 reset tmr", 64'(tmr_irq), 64'h0);
        check("R1 reset err", 64'(err), 64'h0);
        check("R1 reset rdata", rdata, 64'h0);

        op(1, 0, 2'd0, 64'h0000_2000, 2'd0, 0, "R2 R12 ctrl post cpu1");
        op(1, 0, 2'd0, 64'h0000_A000, 2'd1, 0, "R2 ctrl post cpu1,3");
        op(1, 0, 2'd0, 64'h0000_2000, 2'd1, 0, "R7 redundant post");
        op(1, 0, 2'd0, 64'h0000_0100, 2'd2, 0, "R7 clear idle ipi");
        op(1, 0, 2'd0, 64'h0000_0200, 2'd2, 0, "R3 ctrl clear cpu1");
        op(0, 1, 2'd0, 64'h0, 2'd3, 0, "R10 ctrl read");
        op(0, 0, 2'd0, 64'h0, 2'd0, 1, "R8 tick");
        op(1, 0, 2'd0, 64'h0000_0050, 2'd0, 0, "R4 ctrl clear tmr 0,2");
        op(1, 1, 2'd0, 64'h1000_0000, 2'd2, 0, "R5 nxm ack only");
        op(1, 0, 2'd0, 64'hFFFF_0000_0000_000F, 2'd0, 0, "R6 empty ctrl write");
        op(1, 0, 2'd3, 64'h0000_0005, 2'd0, 0, "R9 post sel3");
        op(1, 1, 2'd1, 64'h0000_0001, 2'd0, 0, "R9 clear sel1");
        op(1, 1, 2'd2, 64'h0000_0002, 2'd0, 0, "R9 clear sel2");
        op(1, 0, 2'd3, 64'hFFFF_FFF0, 2'd0, 0, "R9 zero vector sel3");
        op(1, 0, 2'd1, 64'h0, 2'd0, 0, "R9 zero vector sel1");
        op(0, 1, 2'd3, 64'h0, 2'd0, 0, "R10 read sel3");
        op(0, 1, 2'd1, 64'h0, 2'd0, 0, "R10 read sel1");
        op(1, 0, 2'd0, 64'h0000_1100, 2'd0, 0, "R11 post+clear cpu0");
        op(1, 0, 2'd2, 64'h0000_000F, 2'd0, 1, "R11 tick+clear");
        op(1, 1, 2'd0, 64'h0000_FF00, 2'd1, 0, "R11 R10 all post+clear");

        for (int i = 0; i < 600; i++) begin
            logic [63:0] d;
            logic [1:0] s;
            d = '0;
            for (int n = 0; n < 4; n++)
                if ($urandom_range(2) == 0) d[4*n +: 4] = 4'($urandom);
            if ($urandom_range(5) == 0) d[28] = 1'b1;
            if ($urandom_range(3) == 0) d[63:32] = $urandom;
            s = 2'($urandom);
            op(1'($urandom), 1'($urandom), s, d, 2'($urandom),
               ($urandom_range(7) == 0), "R12 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule